// File: doc/BRIEF.md
# Dual-Bank Configuration Register Unit

This block holds the configuration state of a small content-addressable memory: a 64-bit comparand and, in each of two switchable banks (foreground and background), a 16-bit control register plus two 64-bit mask registers. Software reaches the registers over a 16-bit bus with write and read commands. A register select and a segment index pick the 16-bit word. Only the bank currently active can be written or read. The comparand is shared by both banks.

The block decodes the control word as it is written. A control write whose top bit is 0 acts as a soft reset: both control registers go to their defaults and the foreground bank becomes active. Every other bit of that write is dropped. A control write with the top bit set stores the word. It also raises a one-cycle compare request, which the external compare array uses to start a match. Writing segment 3 of the comparand or of either mask register raises the same request. The active control fields, the comparand and the mask chosen by the control register are driven out continuously for the compare array.

Top module: `cfg_bank_unit`

## Requirements
- R1: After the synchronous reset `rst`, the following hold: `mask_sel`=0, `addr_mode`=0 (hold), `match_en`=1, `bank_active`=0 (foreground), `cmp_req`=0, and `cmp_data` and `cmp_mask` are zero.
- R2: `reg_sel`=0 selects the control register. A write to it with `wdata[15]`=1 stores `wdata[14:0]` into the control register of the active bank, and the fields show it in the cycle after the write. The fields are `mask_sel` = bits [1:0], `addr_mode` = bits [3:2] and `match_en` = bit 4. The other bank's control register is unchanged.
- R3: A read (`rd_en`) presents the selected word on `rdata` in the cycle after the request. Bit 15 of a control-register read is always 0.
- R4: A control write with `wdata[15]`=0 is a soft reset, and all of its other bits are ignored. Both banks' control registers return to 16'h0010, the foreground bank becomes active, and no compare request follows. The comparand and the mask registers keep their contents.
- R5: `cmp_req` is high for exactly the one cycle after each control write with `wdata[15]`=1.
- R6: `cmp_req` is high for the one cycle after a write to segment 3 of the comparand (`reg_sel`=1), mask 1 (`reg_sel`=2) or mask 2 (`reg_sel`=3). Writes to segments 0 to 2 raise no request.
- R7: Segment k of a 64-bit register occupies bits [16k+15:16k]. A write updates only that slice, which appears on `cmp_data` (for the comparand) and reads back through `rdata`.
- R8: `bank_we` with `bank_val` (0 foreground, 1 background) switches the active bank from the next cycle on. A write in the same cycle as the switch goes to the previously active bank. The masks and control registers are per bank, and the comparand is shared.
- R9: `cmp_mask` carries the active bank's mask 1 when `mask_sel`=01 and its mask 2 when `mask_sel`=10. For 00 and 11 it is zero, meaning an unmasked compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write command |
| rd_en | input | 1 | Register read command |
| reg_sel | input | 2 | 0 control, 1 comparand, 2 mask 1, 3 mask 2 |
| seg_idx | input | 2 | 16-bit segment of a 64-bit register |
| wdata | input | 16 | Write data |
| bank_we | input | 1 | Load the active-bank selection |
| bank_val | input | 1 | Bank to select: 0 foreground, 1 background |
| rdata | output | 16 | Registered read data |
| cmp_req | output | 1 | One-cycle compare request |
| cmp_data | output | 64 | Comparand value |
| cmp_mask | output | 64 | Mask applied to the compare, zero when unmasked |
| mask_sel | output | 2 | Active mask-select field |
| addr_mode | output | 2 | Active address-mode field |
| match_en | output | 1 | Active match-flag enable |
| bank_active | output | 1 | Currently active bank |

## Verification
A wrong bank pointer is visible on `bank_active` and `cmp_mask` in the cycle after the switch. It also shows on the next read or field update, because writes land in the wrong bank. A control register that stored a soft-reset word, or lost a bit, shows on the field outputs and on `rdata` one cycle after the write. A decoder fault appears as a missing or extra `cmp_req` pulse exactly one cycle after the offending write. The random phase mixes all four registers, all segments and bank switches, so each of these faults is caught within a few operations.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CMPD = 2'd1,
    SEL_MSK1 = 2'd2,
    SEL_MSK2 = 2'd3
  } reg_sel_e;

  localparam int MSEL_LSB  = 0;
  localparam int AMODE_LSB = 2;
  localparam int MFEN_BIT  = 4;

  localparam logic [1:0] MSEL_MR1 = 2'b01;
  localparam logic [1:0] MSEL_MR2 = 2'b10;
endpackage

// File: rtl/cbu_wr_decode.sv
module cbu_wr_decode #(
  parameter int SEG_W    = 2,
  parameter int LAST_SEG = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       reg_sel,
  input  logic [SEG_W-1:0] seg_idx,
  input  logic             wdata_msb,
  output logic             soft_rst,
  output logic             ctrl_we,
  output logic             cmp_req
);
  import cbu_pkg::*;

  logic is_ctrl;
  logic last_seg_wr;

  assign is_ctrl     = (reg_sel == SEL_CTRL);
  assign soft_rst    = wr_en && is_ctrl && !wdata_msb;
  assign ctrl_we     = wr_en && is_ctrl && wdata_msb;
  assign last_seg_wr = wr_en && !is_ctrl && (seg_idx == SEG_W'(LAST_SEG));

  always_ff @(posedge clk) begin
    if (rst) cmp_req <= 1'b0;
    else     cmp_req <= ctrl_we || last_seg_wr;
  end
endmodule

// File: rtl/cbu_ctrl_bank.sv
module cbu_ctrl_bank #(
  parameter int              DATA_W  = 16,
  parameter logic [DATA_W-1:0] DEFAULT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst || soft_rst) ctrl_q <= DEFAULT;
    else if (we)         ctrl_q <= {1'b0, wdata[DATA_W-2:0]};
  end
endmodule

// File: rtl/cbu_seg_store.sv
module cbu_seg_store #(
  parameter int DATA_W = 16,
  parameter int SEGS   = 4,
  parameter int SEG_W  = $clog2(SEGS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [SEG_W-1:0]       seg,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W*SEGS-1:0] value
);
  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst)                          value[s*DATA_W +: DATA_W] <= '0;
      else if (we && seg == SEG_W'(s))  value[s*DATA_W +: DATA_W] <= wdata;
    end
  end
endmodule

// File: rtl/cfg_bank_unit.sv
module cfg_bank_unit #(
  parameter int DATA_W = 16,
  parameter int SEGS   = 4,
  parameter int SEG_W  = $clog2(SEGS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [1:0]             reg_sel,
  input  logic [SEG_W-1:0]       seg_idx,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   bank_we,
  input  logic                   bank_val,
  output logic [DATA_W-1:0]      rdata,
  output logic                   cmp_req,
  output logic [DATA_W*SEGS-1:0] cmp_data,
  output logic [DATA_W*SEGS-1:0] cmp_mask,
  output logic [1:0]             mask_sel,
  output logic [1:0]             addr_mode,
  output logic                   match_en,
  output logic                   bank_active
);
  import cbu_pkg::*;

  localparam int                WIDE_W     = DATA_W * SEGS;
  localparam int                NBANK      = 2;
  localparam logic [DATA_W-1:0] CT_DEFAULT = DATA_W'(1) << MFEN_BIT;

  logic              soft_rst;
  logic              ctrl_we;
  logic              bank_q;
  logic [DATA_W-1:0] ctrl_q [NBANK];
  logic [WIDE_W-1:0] msk1_q [NBANK];
  logic [WIDE_W-1:0] msk2_q [NBANK];
  logic [WIDE_W-1:0] cmpd_q;
  logic [DATA_W-1:0] act_ctrl;

  cbu_wr_decode #(.SEG_W(SEG_W), .LAST_SEG(SEGS-1)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .reg_sel   (reg_sel),
    .seg_idx   (seg_idx),
    .wdata_msb (wdata[DATA_W-1]),
    .soft_rst  (soft_rst),
    .ctrl_we   (ctrl_we),
    .cmp_req   (cmp_req)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_rst) bank_q <= 1'b0;
    else if (bank_we)    bank_q <= bank_val;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel_here;
    assign sel_here = (bank_q == 1'(b));

    cbu_ctrl_bank #(.DATA_W(DATA_W), .DEFAULT(CT_DEFAULT)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .soft_rst (soft_rst),
      .we       (ctrl_we && sel_here),
      .wdata    (wdata),
      .ctrl_q   (ctrl_q[b])
    );

    cbu_seg_store #(.DATA_W(DATA_W), .SEGS(SEGS), .SEG_W(SEG_W)) u_msk1 (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_en && reg_sel == SEL_MSK1 && sel_here),
      .seg   (seg_idx),
      .wdata (wdata),
      .value (msk1_q[b])
    );

    cbu_seg_store #(.DATA_W(DATA_W), .SEGS(SEGS), .SEG_W(SEG_W)) u_msk2 (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_en && reg_sel == SEL_MSK2 && sel_here),
      .seg   (seg_idx),
      .wdata (wdata),
      .value (msk2_q[b])
    );
  end

  cbu_seg_store #(.DATA_W(DATA_W), .SEGS(SEGS), .SEG_W(SEG_W)) u_cmpd (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en && reg_sel == SEL_CMPD),
    .seg   (seg_idx),
    .wdata (wdata),
    .value (cmpd_q)
  );

  assign act_ctrl    = ctrl_q[bank_q];
  assign mask_sel    = act_ctrl[MSEL_LSB +: 2];
  assign addr_mode   = act_ctrl[AMODE_LSB +: 2];
  assign match_en    = act_ctrl[MFEN_BIT];
  assign bank_active = bank_q;
  assign cmp_data    = cmpd_q;

  always_comb begin
    case (mask_sel)
      MSEL_MR1: cmp_mask = msk1_q[bank_q];
      MSEL_MR2: cmp_mask = msk2_q[bank_q];
      default:  cmp_mask = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (reg_sel)
        SEL_CTRL: rdata <= {1'b0, act_ctrl[DATA_W-2:0]};
        SEL_CMPD: rdata <= cmpd_q[seg_idx*DATA_W +: DATA_W];
        SEL_MSK1: rdata <= msk1_q[bank_q][seg_idx*DATA_W +: DATA_W];
        default:  rdata <= msk2_q[bank_q][seg_idx*DATA_W +: DATA_W];
      endcase
    end
  end
endmodule

// File: rtl/cbu_checker.sv
module cbu_checker #(
  parameter int DATA_W = 16,
  parameter int SEGS   = 4,
  parameter int SEG_W  = $clog2(SEGS)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic [1:0]             reg_sel,
  input logic [SEG_W-1:0]       seg_idx,
  input logic [DATA_W-1:0]      wdata,
  input logic [DATA_W-1:0]      rdata,
  input logic                   cmp_req,
  input logic [DATA_W*SEGS-1:0] cmp_data,
  input logic [DATA_W*SEGS-1:0] cmp_mask,
  input logic [1:0]             mask_sel,
  input logic [1:0]             addr_mode,
  input logic                   match_en,
  input logic                   bank_active
);
  logic srst_wr;
  logic trig_wr;
  assign srst_wr = wr_en && reg_sel == 2'd0 && !wdata[DATA_W-1];
  assign trig_wr = wr_en && ((reg_sel == 2'd0 && wdata[DATA_W-1]) ||
                             (reg_sel != 2'd0 && seg_idx == SEG_W'(SEGS-1)));

  p_req_cause_r5: assert property (@(posedge clk) disable iff (rst)
    cmp_req |-> $past(trig_wr));

  p_req_follows_r6: assert property (@(posedge clk) disable iff (rst)
    trig_wr |=> cmp_req);

  p_softrst_defaults_r4: assert property (@(posedge clk) disable iff (rst)
    srst_wr |=> (!cmp_req && match_en && mask_sel == 2'd0 &&
                 addr_mode == 2'd0 && !bank_active));

  p_softrst_keeps_cmpd_r4: assert property (@(posedge clk) disable iff (rst)
    srst_wr |=> $stable(cmp_data));

  p_ctrl_msb_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_sel == 2'd0) |=> !rdata[DATA_W-1]);

  p_unmasked_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (mask_sel == 2'd0 || mask_sel == 2'd3) |-> cmp_mask == '0);
endmodule

bind cfg_bank_unit cbu_checker #(.DATA_W(DATA_W), .SEGS(SEGS), .SEG_W(SEG_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .reg_sel     (reg_sel),
  .seg_idx     (seg_idx),
  .wdata       (wdata),
  .rdata       (rdata),
  .cmp_req     (cmp_req),
  .cmp_data    (cmp_data),
  .cmp_mask    (cmp_mask),
  .mask_sel    (mask_sel),
  .addr_mode   (addr_mode),
  .match_en    (match_en),
  .bank_active (bank_active)
);

// File: tb/cfg_bank_unit_tb.sv
module cfg_bank_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en, bank_we, bank_val;
  logic [1:0]  reg_sel, seg_idx;
  logic [15:0] wdata, rdata;
  logic        cmp_req, match_en, bank_active;
  logic [63:0] cmp_data, cmp_mask;
  logic [1:0]  mask_sel, addr_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [15:0] m_ctrl [2];
  logic [15:0] m_m1 [2][4];
  logic [15:0] m_m2 [2][4];
  logic [15:0] m_cmpd [4];
  logic        m_bank;

  always #10 clk = ~clk;

  cfg_bank_unit u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .seg_idx(seg_idx), .wdata(wdata), .bank_we(bank_we), .bank_val(bank_val),
    .rdata(rdata), .cmp_req(cmp_req), .cmp_data(cmp_data), .cmp_mask(cmp_mask),
    .mask_sel(mask_sel), .addr_mode(addr_mode), .match_en(match_en),
    .bank_active(bank_active)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_mask();
    logic [15:0] c = m_ctrl[m_bank];
    case (c[1:0])
      2'b01:   return {m_m1[m_bank][3], m_m1[m_bank][2], m_m1[m_bank][1], m_m1[m_bank][0]};
      2'b10:   return {m_m2[m_bank][3], m_m2[m_bank][2], m_m2[m_bank][1], m_m2[m_bank][0]};
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic [15:0] exp_read(input logic [1:0] s, input logic [1:0] g);
    case (s)
      2'd0:    return {1'b0, m_ctrl[m_bank][14:0]};
      2'd1:    return m_cmpd[g];
      2'd2:    return m_m1[m_bank][g];
      default: return m_m2[m_bank][g];
    endcase
  endfunction

  task automatic model_reset();
    m_ctrl[0] = 16'h0010; m_ctrl[1] = 16'h0010; m_bank = 1'b0;
    for (int b = 0; b < 2; b++)
      for (int g = 0; g < 4; g++) begin
        m_m1[b][g] = '0; m_m2[b][g] = '0;
      end
    for (int g = 0; g < 4; g++) m_cmpd[g] = '0;
  endtask

  task automatic check_outputs(input string tag);
    chk({tag, " match_en"},  64'(match_en),    64'(m_ctrl[m_bank][4]));
    chk({tag, " mask_sel"},  64'(mask_sel),    64'(m_ctrl[m_bank][1:0]));
    chk({tag, " addr_mode"}, 64'(addr_mode),   64'(m_ctrl[m_bank][3:2]));
    chk({tag, " bank"},      64'(bank_active), 64'(m_bank));
    chk({tag, " cmp_data"},  cmp_data, {m_cmpd[3], m_cmpd[2], m_cmpd[1], m_cmpd[0]});
    chk({tag, " cmp_mask"},  cmp_mask, exp_mask());
  endtask

  // one operation per clock: drive at negedge, check at the following negedge
  task automatic step(input logic we, input logic [1:0] s, input logic [1:0] g,
                      input logic [15:0] d, input logic re, input logic bwe,
                      input logic bv, input string tag);
    logic        e_req;
    logic [15:0] e_rd;
    wr_en = we; rd_en = re; reg_sel = s; seg_idx = g; wdata = d;
    bank_we = bwe; bank_val = bv;
    e_rd  = exp_read(s, g);
    e_req = we && ((s == 2'd0 && d[15]) || (s != 2'd0 && g == 2'd3));
    if (we && s == 2'd0 && !d[15]) begin
      m_ctrl[0] = 16'h0010; m_ctrl[1] = 16'h0010; m_bank = 1'b0;
    end else begin
      if (we) begin
        case (s)
          2'd0: m_ctrl[m_bank] = {1'b0, d[14:0]};
          2'd1: m_cmpd[g] = d;
          2'd2: m_m1[m_bank][g] = d;
          default: m_m2[m_bank][g] = d;
        endcase
      end
      if (bwe) m_bank = bv;
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; bank_we = 1'b0;
    chk({tag, " cmp_req"}, 64'(cmp_req), 64'(e_req));
    check_outputs(tag);
    if (re) chk({tag, " rdata"}, 64'(rdata), 64'(e_rd));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    rst = 1'b1; wr_en = 0; rd_en = 0; bank_we = 0; bank_val = 0;
    reg_sel = 0; seg_idx = 0; wdata = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1 cmp_req", 64'(cmp_req), 64'd0);
    check_outputs("R1");
    // R2 control write to foreground, R3 readback with msb cleared
    step(1, 2'd0, 2'd0, 16'hFFE9, 0, 0, 0, "R2");
    step(0, 2'd0, 2'd0, 16'h0, 1, 0, 0, "R3");
    // R7 segment writes 0..2 give no request (R6), then segment 3 does
    step(1, 2'd1, 2'd0, 16'h1111, 0, 0, 0, "R6 seg0");
    step(1, 2'd1, 2'd1, 16'h2222, 0, 0, 0, "R6 seg1");
    step(1, 2'd1, 2'd2, 16'h3333, 0, 0, 0, "R6 seg2");
    step(1, 2'd1, 2'd3, 16'h4444, 1, 0, 0, "R6 seg3");
    step(0, 2'd1, 2'd2, 16'h0, 1, 0, 0, "R7");
    // masks in foreground, R9 selection
    step(1, 2'd2, 2'd3, 16'hA5A5, 0, 0, 0, "R9 m1");
    step(1, 2'd3, 2'd0, 16'h5A5A, 0, 0, 0, "R9 m2");
    step(1, 2'd0, 2'd0, 16'h8002, 0, 0, 0, "R9 sel2");
    step(1, 2'd0, 2'd0, 16'h8003, 0, 0, 0, "R9 sel3");
    // R8 bank switch; write in same cycle reaches old bank
    step(1, 2'd0, 2'd0, 16'h8001, 0, 1, 1, "R8 switch");
    step(1, 2'd2, 2'd3, 16'h0F0F, 0, 0, 0, "R8 bg m1");
    step(1, 2'd0, 2'd0, 16'h800D, 0, 0, 0, "R8 bg ctrl");
    step(0, 2'd2, 2'd3, 16'h0, 1, 1, 0, "R8 back");
    step(0, 2'd2, 2'd3, 16'h0, 1, 0, 0, "R8 fg m1");
    // R4 soft reset from background with junk bits, then readback
    step(0, 2'd0, 2'd0, 16'h0, 0, 1, 1, "R8 to bg");
    step(1, 2'd0, 2'd0, 16'h7FFF, 0, 0, 0, "R4 softrst");
    step(0, 2'd0, 2'd0, 16'h0, 1, 0, 0, "R4 readback");
    step(0, 2'd1, 2'd3, 16'h0, 1, 0, 0, "R4 cmpd kept");
    // R5 back-to-back control writes give back-to-back pulses
    step(1, 2'd0, 2'd0, 16'h8011, 0, 0, 0, "R5 a");
    step(1, 2'd0, 2'd0, 16'h8012, 0, 0, 0, "R5 b");
    step(0, 2'd0, 2'd0, 16'h0, 0, 0, 0, "R5 idle");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  s  = 2'($urandom_range(0, 3));
      logic [1:0]  g  = 2'($urandom_range(0, 3));
      logic [15:0] d  = 16'($urandom);
      logic        we = ($urandom_range(0, 3) != 0);
      if (s == 2'd0 && $urandom_range(0, 7) != 0) d[15] = 1'b1;
      step(we, s, g, d, 1'($urandom_range(0, 1)),
           ($urandom_range(0, 5) == 0), 1'($urandom_range(0, 1)), "R2-rand R5 R6 R7 R8 R9");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule